// File: doc/BRIEF.md
# Prescaled Phase-Accumulator Square-Wave Generator

This block produces a square wave whose frequency is set by two values: a base period, counted in system clocks, and a phase step. A prescaler divides the system clock into accumulation ticks, one every base period. On each tick the phase step is added to a wide phase accumulator. The top bit of the accumulator is the output wave. Each time the addition wraps past the top of the accumulator, a flag pulses for one clock.

The output frequency is f_clk × step / (2^ACC_W × period). With the default widths, a step of 0x8000_0000 and a period of 1000 toggle the output every 1000 clocks. The result is a square wave at 1/2000 of the clock.

A disabled generator holds all of its state at zero. Enabling it starts counting from that clean state. A separate output-enable input gates the wave before it leaves the block.

Top module: `nco_prescaled`

## Requirements
- R1: While `run_en` is high, one accumulation tick happens every `base_period` clocks. The first tick happens on the base_period-th rising edge after `run_en` is first sampled high.
- R2: On each tick the accumulator takes the value accumulator + `phase_step`, modulo 2^32. `wave_out` equals bit 31 of the accumulator. Between ticks the accumulator does not change.
- R3: A `base_period` of 0 gives a base period of 65536 clocks.
- R4: `wrap_flag` is high for exactly one clock, right after every tick whose addition carries out of bit 31. It is low at all other times.
- R5: While `run_en` is low, the accumulator and prescaler are held at zero, `wave_out` is low and `wrap_flag` is low. Re-enabling restarts from zero.
- R6: A change of `phase_step` affects the output only at the next tick.
- R7: A change of `base_period` takes effect only after the base period that is running completes. The new value is captured at that reload.
- R8: While `out_en` is low, `wave_out` is low and the accumulator keeps running. When `out_en` rises, the current accumulator top bit appears in the same cycle.
- R9: After reset, `wave_out` and `wrap_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Enables the prescaler and accumulator; low holds them at zero |
| base_period | input | 16 | Clocks per accumulation tick (0 means 65536) |
| phase_step | input | 32 | Value added to the accumulator on each tick |
| out_en | input | 1 | Lets the wave reach `wave_out` |
| wave_out | output | 1 | Accumulator top bit, gated by `out_en` |
| wrap_flag | output | 1 | One-clock pulse on accumulator carry-out |

## Verification
A prescaler count that is off by one moves the first output edge by one clock, so the fault shows within one base period of enabling. A dropped or extra tick changes how many `wrap_flag` pulses appear, and that shows by the end of a few accumulator wraps. A limit captured at the wrong moment shifts the next edge right after a period change. An accumulator that is not cleared while idle gives the wrong level on the first tick after re-enabling.

// File: rtl/nco_pkg.sv
package nco_pkg;
   localparam int DEF_PER_W = 16;
   localparam int DEF_ACC_W = 32;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;
endpackage

// File: rtl/nco_prescaler.sv
module nco_prescaler #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PER_W-1:0] period_i,
   output logic             tick_o
);
   localparam logic [PER_W-1:0] ONE = PER_W'(1);

   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] lim_q;
   logic [PER_W-1:0] last_cnt;

   // A limit of 0 wraps to all ones: a full 2^PER_W count
   assign last_cnt = lim_q - ONE;
   assign tick_o   = en && (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (!en) begin
         cnt_q <= '0;
         lim_q <= period_i;
      end else if (tick_o) begin
         cnt_q <= '0;
         lim_q <= period_i;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   // R5
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt_q == '0);

   // R1
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !tick_o |=> cnt_q == $past(cnt_q) + ONE);

   // R7
   lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !tick_o |=> $stable(lim_q));
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick_i,
   input  logic [ACC_W-1:0] step_i,
   output logic             msb_o,
   output logic             carry_o
);
   logic [ACC_W-1:0] acc_q;
   logic             ovf_q;
   logic [ACC_W:0]   sum;

   assign sum     = {1'b0, acc_q} + {1'b0, step_i};
   assign msb_o   = acc_q[ACC_W-1];
   assign carry_o = ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else if (!en) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= tick_i && sum[ACC_W];
         if (tick_i) acc_q <= sum[ACC_W-1:0];
      end
   end

   // R2
   acc_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && tick_i |=> acc_q == $past(acc_q) + $past(step_i));

   // R6
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en && !tick_i |=> $stable(acc_q));

   // R4
   ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> $past(tick_i) && $past(en));

   // R4
   ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> !ovf_q || $past(tick_i));
endmodule

// File: rtl/nco_outstage.sv
module nco_outstage #(
   parameter nco_pkg::out_mode_e MODE = nco_pkg::OUT_COMB
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wave_i,
   input  logic oe_i,
   output logic wave_o
);
   generate
      if (MODE == nco_pkg::OUT_REG) begin : g_reg
         logic wave_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wave_q <= 1'b0;
            else        wave_q <= wave_i && oe_i;
         end
         assign wave_o = wave_q;

         // R8
         gate_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_i |=> !wave_o);
      end else begin : g_comb
         assign wave_o = wave_i && oe_i;
      end
   endgenerate
endmodule

// File: rtl/nco_prescaled.sv
module nco_prescaled #(
   parameter int                 PER_W    = nco_pkg::DEF_PER_W,
   parameter int                 ACC_W    = nco_pkg::DEF_ACC_W,
   parameter nco_pkg::out_mode_e OUT_MODE = nco_pkg::OUT_COMB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [PER_W-1:0] base_period,
   input  logic [ACC_W-1:0] phase_step,
   input  logic             out_en,
   output logic             wave_out,
   output logic             wrap_flag
);
   generate
      if (PER_W < 1 || PER_W > 32) begin : g_bad_per
         $error("PER_W must lie in 1..32");
      end
      if (ACC_W < 2 || ACC_W > 64) begin : g_bad_acc
         $error("ACC_W must lie in 2..64");
      end
   endgenerate

   logic tick;
   logic acc_msb;

   nco_prescaler #(.PER_W(PER_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (run_en),
      .period_i (base_period),
      .tick_o   (tick)
   );

   nco_accum #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (run_en),
      .tick_i  (tick),
      .step_i  (phase_step),
      .msb_o   (acc_msb),
      .carry_o (wrap_flag)
   );

   nco_outstage #(.MODE(OUT_MODE)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .wave_i (acc_msb),
      .oe_i   (out_en),
      .wave_o (wave_out)
   );

   // R5
   idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !wave_out && !wrap_flag);

   // R4
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_flag |-> $past(tick));
endmodule

// File: tb/nco_prescaled_test.sv
module nco_prescaled_test;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [15:0] period;
      logic [31:0] step;
      logic [31:0] ncyc;
      logic        exp_wave;
      logic [7:0]  exp_ovf;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{16'd4,    32'h4000_0000, 32'd20,   1'b0, 8'd1},
      '{16'd1,    32'h8000_0000, 32'd7,    1'b1, 8'd3},
      '{16'd3,    32'h6000_0000, 32'd10,   1'b0, 8'd1},
      '{16'd5,    32'hC000_0000, 32'd12,   1'b1, 8'd1},
      '{16'd2,    32'h1000_0000, 32'd17,   1'b1, 8'd0},
      '{16'd1000, 32'h8000_0000, 32'd999,  1'b0, 8'd0},
      '{16'd1000, 32'h8000_0000, 32'd1000, 1'b1, 8'd0},
      '{16'd1000, 32'h8000_0000, 32'd2000, 1'b0, 8'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [15:0] base_period = 16'd1;
   logic [31:0] phase_step = '0;
   logic        out_en = 1'b1;
   logic        wave_out;
   logic        wrap_flag;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nco_prescaled uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .base_period (base_period),
      .phase_step  (phase_step),
      .out_en      (out_en),
      .wave_out    (wave_out),
      .wrap_flag   (wrap_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n, output int ovfs);
      ovfs = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (wrap_flag) ovfs++;
      end
   endtask

   task automatic go_idle();
      int d;
      @(negedge clk);
      run_en = 1'b0;
      step(2, d);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int n_ovf;
      int d;
      // R9 reset state
      repeat (3) @(negedge clk);
      chk("R9 wave", 32'(wave_out), 32'd0);
      chk("R9 flag", 32'(wrap_flag), 32'd0);
      rst_n = 1'b1;
      step(2, d);

      // R1 R2 R4 vector table
      for (int v = 0; v < NVEC; v++) begin
         go_idle();
         base_period = VECS[v].period;
         phase_step  = VECS[v].step;
         step(1, d);
         run_en = 1'b1;
         step(int'(VECS[v].ncyc), n_ovf);
         chk("R1/R2 wave", 32'(wave_out), 32'(VECS[v].exp_wave));
         chk("R4 flag count", 32'(n_ovf), 32'(VECS[v].exp_ovf));
      end

      // R5: disable while wave high, then restart from zero
      go_idle();
      base_period = 16'd1;
      phase_step  = 32'h8000_0000;
      step(1, d);
      run_en = 1'b1;
      step(1, d);
      chk("R5 pre wave", 32'(wave_out), 32'd1);
      run_en = 1'b0;
      step(5, n_ovf);
      chk("R5 idle wave", 32'(wave_out), 32'd0);
      chk("R5 idle flag", 32'(n_ovf), 32'd0);
      run_en = 1'b1;
      step(1, n_ovf);
      chk("R5 restart wave", 32'(wave_out), 32'd1);
      chk("R5 restart flag", 32'(n_ovf), 32'd0);

      // R8: output gate
      go_idle();
      base_period = 16'd2;
      phase_step  = 32'h8000_0000;
      out_en = 1'b0;
      step(1, d);
      run_en = 1'b1;
      step(2, d);
      chk("R8 gated", 32'(wave_out), 32'd0);
      out_en = 1'b1;
      #1;
      chk("R8 released", 32'(wave_out), 32'd1);

      // R6: step change applies at next tick only
      go_idle();
      base_period = 16'd4;
      phase_step  = 32'h4000_0000;
      step(1, d);
      run_en = 1'b1;
      step(4, d);
      chk("R6 first tick", 32'(wave_out), 32'd0);
      phase_step = 32'hC000_0000;
      step(2, n_ovf);
      chk("R6 between ticks wave", 32'(wave_out), 32'd0);
      chk("R6 between ticks flag", 32'(n_ovf), 32'd0);
      step(2, n_ovf);
      chk("R6 new step wrap", 32'(n_ovf), 32'd1);
      chk("R6 new step wave", 32'(wave_out), 32'd0);

      // R7: period change waits for reload
      go_idle();
      base_period = 16'd4;
      phase_step  = 32'h4000_0000;
      step(1, d);
      run_en = 1'b1;
      step(4, d);
      base_period = 16'd2;
      step(2, d);
      chk("R7 old period kept", 32'(wave_out), 32'd0);
      step(2, d);
      chk("R7 second tick", 32'(wave_out), 32'd1);
      step(2, n_ovf);
      chk("R7 new period tick", 32'(wave_out), 32'd1);
      chk("R7 no wrap yet", 32'(n_ovf), 32'd0);
      step(2, n_ovf);
      chk("R7 wrap at new period", 32'(n_ovf), 32'd1);

      // R3: period 0 means 65536
      go_idle();
      base_period = 16'd0;
      phase_step  = 32'h8000_0000;
      step(1, d);
      run_en = 1'b1;
      step(65535, d);
      chk("R3 before full count", 32'(wave_out), 32'd0);
      step(1, d);
      chk("R3 at full count", 32'(wave_out), 32'd1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule